// File: doc/BRIEF.md
# Single-Wire Bus Slave Acknowledge and Addressing Controller

This block sits behind the bit-level receiver of a slave on a single-wire, Manchester-coded serial memory bus. The receiver hands it one strobe per bit period (`bit_stb`) together with the decoded master bit (`bit_val`). The controller follows the frame: a synchronising header byte, the device address byte, the command byte and then any number of data bytes. After every byte it runs an acknowledge slot of two bit periods. In the first period it samples the master's continue bit (1 = continue, 0 = stop). In the second period it either asks the output driver to send a '1' or keeps the driver off, so that no mid-bit edge appears.

Whether the slave acknowledges depends on where the frame stands and on the bits received. The header is never acknowledged. The address must carry family nibble 1010 and device nibble 0000. Commands are screened against a parameter table of opcodes, and some opcodes are refused while the memory core reports a write cycle in progress. A write-type command that ends correctly raises a one-cycle `write_start`. Once the frame ends, or once it fails, the controller ignores all bits until a standby pulse returns it to header search.

Top module: `swb_hs_ctrl`

## Requirements
- R1: Bits arrive MSB first, one per `bit_stb`. The first byte after standby must be 0x55. A matching header is always answered with no acknowledge (`sak_drive` low in its slave slot). Any other first byte makes the block ignore all later bits until standby.
- R2: A stop bit (0) in the master slot after the header ends the frame. No later slot is acknowledged until standby.
- R3: Address byte 0xA0 (upper nibble 1010, lower nibble 0000) is acknowledged. Any other address gets no acknowledge and ends the frame.
- R4: A stop bit after a matching address is still acknowledged. The frame then ends and no command is taken.
- R5: An opcode that is not in the command table gets no acknowledge and ends the frame. The default table has read 0x03, sequential read 0x06, write 0x6C, write-enable 0x96, write-disable 0x91, status read 0x05, status write 0x6E, erase-all 0x6D and set-all 0x67, with table indices 0 to 8 in that order.
- R6: While `busy` is high, read, sequential read, write, status write, erase-all and set-all get no acknowledge. Status read, write-enable and write-disable are still accepted.
- R7: A command that takes data and is followed by a continue bit is acknowledged. Every data byte followed by a continue bit is acknowledged too.
- R8: A data-taking command that is stopped right after the command byte gets no acknowledge and no `write_start`.
- R9: A stop bit after one or more data bytes is acknowledged and ends the frame. `write_start` pulses for exactly one cycle if the command is write or status write, and stays low for read-type commands.
- R10: A command without data is accepted only with a stop bit. Erase-all and set-all then also pulse `write_start`. A continue bit after such a command gets no acknowledge.
- R11: `sync_err` high in any cycle ends the frame. No later slot is acknowledged until standby.
- R12: `standby` returns the block to header search from any state in the next cycle, including part-way through a byte.
- R13: Slot results appear in the cycle after the master-bit strobe. `sak_drive` holds until the next `bit_stb` and is low at all other times. `cmd_ok` pulses for one cycle with `cmd_idx` equal to the table index when a command is acknowledged. `sak_drive`, `write_start` and `cmd_ok` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Standby pulse seen on the bus; restarts header search |
| sync_err | input | 1 | Receiver lost bit synchronisation |
| bit_stb | input | 1 | One-cycle strobe per bit period |
| bit_val | input | 1 | Decoded master bit, valid with `bit_stb` |
| busy | input | 1 | Memory core write cycle in progress |
| sak_drive | output | 1 | Send a '1' in the current slave slot |
| write_start | output | 1 | One-cycle request to begin the write cycle |
| cmd_ok | output | 1 | One-cycle pulse when a command is acknowledged |
| cmd_idx | output | 4 | Table index of the last accepted command |

## Verification
The hardest cases are the ones where the slave must stay silent deep in a frame whose earlier bytes were all correct. Examples are a write stopped before any data byte, a blocked opcode arriving while `busy` is high, and a loss of sync between address and command. The stimulus reaches them by building full frames: standby pulse, header, matching address and an accepted slot. Only then does it apply the faulty command, the stop bit, `busy` or `sync_err`. After each silent slot it sends one more correct-looking byte, to show that the halted state ignores it until the next standby.

// File: rtl/swb_pkg.sv
package swb_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] HDR_PATTERN = 8'h55;
    localparam logic [3:0]        FAMILY_NIB  = 4'hA;
    localparam logic [3:0]        DEVICE_NIB  = 4'h0;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_ADDR,
        PH_CMD,
        PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        ST_BYTE,
        ST_MACK,
        ST_SACK,
        ST_HALT
    } step_e;

    typedef struct packed {
        step_e  step;
        phase_e phase;
        phase_e nxt;
        logic   cont;
        logic   sak;
    } frame_t;

    typedef struct packed {
        logic hit;
        logic has_data;
        logic is_wr;
        logic blk;
    } cmd_attr_t;

    localparam frame_t FRAME_IDLE = '{step: ST_BYTE, phase: PH_HDR, nxt: PH_HDR,
                                      cont: 1'b0, sak: 1'b0};

    function automatic logic addr_match(input logic [BYTE_W-1:0] b);
        return (b[7:4] == FAMILY_NIB) && (b[3:0] == DEVICE_NIB);
    endfunction

endpackage

// File: rtl/swb_byte_rx.sv
module swb_byte_rx
    import swb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              stb,
    input  logic              val,
    output logic              done,
    output logic [BYTE_W-1:0] byte_now
);

    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    assign done     = en && stb && (cnt == LAST);
    assign byte_now = {sh[BYTE_W-2:0], val};

    always_ff @(posedge clk) begin
        if (rst || clr || !en) begin
            cnt <= '0;
            if (rst) sh <= '0;
        end else if (stb) begin
            sh  <= byte_now;
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/swb_cmd_dec.sv
module swb_cmd_dec
    import swb_pkg::*;
#(
    parameter int NCMD = 9,
    parameter int IDXW = $clog2(NCMD),
    parameter logic [0:NCMD-1][BYTE_W-1:0] OPS = '{8'h03, 8'h06, 8'h6C, 8'h96,
                                                   8'h91, 8'h05, 8'h6E, 8'h6D, 8'h67},
    parameter logic [0:NCMD-1] HAS_DATA = 9'b111001100,
    parameter logic [0:NCMD-1] IS_WR    = 9'b001000111,
    parameter logic [0:NCMD-1] BLK      = 9'b111000111
) (
    input  logic [BYTE_W-1:0] opcode,
    output cmd_attr_t         attr,
    output logic [IDXW-1:0]   idx
);

    logic [NCMD-1:0] match;

    for (genvar i = 0; i < NCMD; i++) begin : g_cmp
        assign match[i] = (opcode == OPS[i]);
    end

    always_comb begin
        attr = '0;
        idx  = '0;
        for (int i = NCMD - 1; i >= 0; i--) begin
            if (match[i]) begin
                attr.hit      = 1'b1;
                attr.has_data = HAS_DATA[i];
                attr.is_wr    = IS_WR[i];
                attr.blk      = BLK[i];
                idx           = IDXW'(i);
            end
        end
    end

    always_comb begin
        if (!$isunknown(match))
            assert_unique_ops_R5: assert ($onehot0(match));
    end

endmodule

// File: rtl/swb_hs_ctrl.sv
module swb_hs_ctrl
    import swb_pkg::*;
#(
    parameter int NCMD = 9,
    parameter int IDXW = 4,
    parameter logic [0:NCMD-1][BYTE_W-1:0] OPS = '{8'h03, 8'h06, 8'h6C, 8'h96,
                                                   8'h91, 8'h05, 8'h6E, 8'h6D, 8'h67},
    parameter logic [0:NCMD-1] HAS_DATA = 9'b111001100,
    parameter logic [0:NCMD-1] IS_WR    = 9'b001000111,
    parameter logic [0:NCMD-1] BLK      = 9'b111000111
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            standby,
    input  logic            sync_err,
    input  logic            bit_stb,
    input  logic            bit_val,
    input  logic            busy,
    output logic            sak_drive,
    output logic            write_start,
    output logic            cmd_ok,
    output logic [IDXW-1:0] cmd_idx
);

    frame_t            fr, nx;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_now;
    logic [BYTE_W-1:0] last_byte;
    cmd_attr_t         attr;
    logic [IDXW-1:0]   dec_idx;
    logic              wr_q;
    logic              ws_n, ok_n, accept;

    swb_byte_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .clr      (standby),
        .en       (fr.step == ST_BYTE),
        .stb      (bit_stb),
        .val      (bit_val),
        .done     (byte_done),
        .byte_now (byte_now)
    );

    swb_cmd_dec #(
        .NCMD     (NCMD),
        .IDXW     (IDXW),
        .OPS      (OPS),
        .HAS_DATA (HAS_DATA),
        .IS_WR    (IS_WR),
        .BLK      (BLK)
    ) u_dec (
        .opcode (last_byte),
        .attr   (attr),
        .idx    (dec_idx)
    );

    assign accept = attr.hit && !(busy && attr.blk);

    always_comb begin
        nx   = fr;
        ws_n = 1'b0;
        ok_n = 1'b0;
        if (standby) begin
            nx = FRAME_IDLE;
        end else if (sync_err) begin
            nx.step = ST_HALT;
            nx.sak  = 1'b0;
        end else begin
            unique case (fr.step)
                ST_BYTE: begin
                    if (byte_done)
                        nx.step = (fr.phase == PH_HDR && byte_now != HDR_PATTERN)
                                  ? ST_HALT : ST_MACK;
                end
                ST_MACK: begin
                    if (bit_stb) begin
                        nx.step = ST_SACK;
                        nx.sak  = 1'b0;
                        nx.cont = 1'b0;
                        nx.nxt  = fr.phase;
                        unique case (fr.phase)
                            PH_HDR: begin
                                nx.cont = bit_val;
                                nx.nxt  = PH_ADDR;
                            end
                            PH_ADDR: begin
                                if (addr_match(last_byte)) begin
                                    nx.sak  = 1'b1;
                                    nx.cont = bit_val;
                                    nx.nxt  = PH_CMD;
                                end
                            end
                            PH_CMD: begin
                                if (accept) begin
                                    if (attr.has_data) begin
                                        if (bit_val) begin
                                            nx.sak  = 1'b1;
                                            nx.cont = 1'b1;
                                            nx.nxt  = PH_DATA;
                                            ok_n    = 1'b1;
                                        end
                                    end else if (!bit_val) begin
                                        nx.sak = 1'b1;
                                        ok_n   = 1'b1;
                                        ws_n   = attr.is_wr;
                                    end
                                end
                            end
                            PH_DATA: begin
                                nx.sak  = 1'b1;
                                nx.cont = bit_val;
                                ws_n    = !bit_val && wr_q;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_SACK: begin
                    if (bit_stb) begin
                        nx.step  = fr.cont ? ST_BYTE : ST_HALT;
                        nx.phase = fr.nxt;
                        nx.sak   = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr          <= FRAME_IDLE;
            last_byte   <= '0;
            wr_q        <= 1'b0;
            write_start <= 1'b0;
            cmd_ok      <= 1'b0;
            cmd_idx     <= '0;
        end else begin
            fr          <= nx;
            write_start <= ws_n;
            cmd_ok      <= ok_n;
            if (byte_done) last_byte <= byte_now;
            if (ok_n) begin
                cmd_idx <= dec_idx;
                wr_q    <= attr.is_wr;
            end
        end
    end

    assign sak_drive = (fr.step == ST_SACK) && fr.sak;

    assert_hdr_nosak_R1: assert property (@(posedge clk) disable iff (rst)
        (fr.step == ST_MACK && fr.phase == PH_HDR && bit_stb) |=> !sak_drive);

    assert_addr_miss_R3: assert property (@(posedge clk) disable iff (rst)
        (fr.step == ST_MACK && fr.phase == PH_ADDR && bit_stb && !addr_match(last_byte))
        |=> !sak_drive);

    assert_busy_block_R6: assert property (@(posedge clk) disable iff (rst)
        (fr.step == ST_MACK && fr.phase == PH_CMD && bit_stb && busy && attr.blk)
        |=> (!sak_drive && !cmd_ok));

    assert_ws_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        write_start |=> !write_start);

    assert_ws_with_sak_R9: assert property (@(posedge clk) disable iff (rst)
        write_start |-> sak_drive);

    assert_ok_with_sak_R13: assert property (@(posedge clk) disable iff (rst)
        cmd_ok |-> sak_drive);

    assert_standby_idle_R12: assert property (@(posedge clk) disable iff (rst)
        standby |=> (fr.step == ST_BYTE && fr.phase == PH_HDR && !sak_drive));

    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (fr.step == ST_HALT && !standby) |=> (fr.step == ST_HALT));

endmodule

// File: tb/test_swb_hs_ctrl.sv
module test_swb_hs_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby = 1'b0;
    logic       sync_err = 1'b0;
    logic       bit_stb = 1'b0;
    logic       bit_val = 1'b0;
    logic       busy = 1'b0;
    logic       sak_drive;
    logic       write_start;
    logic       cmd_ok;
    logic [3:0] cmd_idx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swb_hs_ctrl i_swb_hs_ctrl (
        .clk         (clk),
        .rst         (rst),
        .standby     (standby),
        .sync_err    (sync_err),
        .bit_stb     (bit_stb),
        .bit_val     (bit_val),
        .busy        (busy),
        .sak_drive   (sak_drive),
        .write_start (write_start),
        .cmd_ok      (cmd_ok),
        .cmd_idx     (cmd_idx)
    );

    typedef struct {
        bit    sak;
        bit    ws;
        bit    ok;
        int    idx;
        string tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    task automatic chk(input bit good, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // monitor: pops the expected slot outcome and compares
    initial begin
        forever begin
            exp_t e;
            @(chk_ev);
            e = q.pop_front();
            chk(sak_drive == e.sak, e.tag, "sak_drive", int'(sak_drive), int'(e.sak));
            chk(write_start == e.ws, e.tag, "write_start", int'(write_start), int'(e.ws));
            chk(cmd_ok == e.ok, e.tag, "cmd_ok", int'(cmd_ok), int'(e.ok));
            if (e.ok) chk(int'(cmd_idx) == e.idx, e.tag, "cmd_idx", int'(cmd_idx), e.idx);
            @(negedge clk);
            chk(write_start == 1'b0, "R9", "write_start width", int'(write_start), 0);
            @(negedge clk);
            chk(sak_drive == 1'b0, "R13", "sak after slot", int'(sak_drive), 0);
        end
    end

    task automatic send_bit(input bit v);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_val = v;
        @(negedge clk);
        bit_stb = 1'b0;
        bit_val = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic slot(input bit m, input bit es, input bit ews, input bit eok,
                        input int eidx, input string tag);
        exp_t e;
        send_bit(m);
        e.sak = es; e.ws = ews; e.ok = eok; e.idx = eidx; e.tag = tag;
        q.push_back(e);
        -> chk_ev;
        send_bit(1'b0);
        @(negedge clk);
    endtask

    task automatic sby();
        @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
    endtask

    task automatic open_frame();
        sby();
        send_byte(8'h55);
        slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R1");
        send_byte(8'hA0);
        slot(1'b1, 1'b1, 1'b0, 1'b0, 0, "R3");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sak_drive == 1'b0, "R13", "reset sak", int'(sak_drive), 0);
        chk(write_start == 1'b0, "R13", "reset ws", int'(write_start), 0);
        chk(cmd_ok == 1'b0, "R13", "reset cmd_ok", int'(cmd_ok), 0);

        // R7 R9 R13: write with two data bytes
        open_frame();
        send_byte(8'h6C); slot(1'b1, 1'b1, 1'b0, 1'b1, 2, "R7");
        send_byte(8'h12); slot(1'b1, 1'b1, 1'b0, 1'b0, 0, "R7");
        send_byte(8'h34); slot(1'b0, 1'b1, 1'b1, 1'b0, 0, "R9");

        // R4: stop after address; later command ignored (R12)
        sby();
        send_byte(8'h55); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R1");
        send_byte(8'hA0); slot(1'b0, 1'b1, 1'b0, 1'b0, 0, "R4");
        send_byte(8'h03); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R4");

        // R1: wrong header, then ignored
        sby();
        send_byte(8'h54);
        send_byte(8'hA0); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R1");

        // R2: stop after header
        sby();
        send_byte(8'h55); slot(1'b0, 1'b0, 1'b0, 1'b0, 0, "R2");
        send_byte(8'hA0); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R2");

        // R3: wrong address
        sby();
        send_byte(8'h55); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R1");
        send_byte(8'hA1); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R3");
        send_byte(8'h03); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R3");

        // R5: unknown opcode
        open_frame();
        send_byte(8'h42); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R5");

        // R6: busy blocks write, status read passes
        busy = 1'b1;
        open_frame();
        send_byte(8'h6C); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R6");
        open_frame();
        send_byte(8'h05); slot(1'b1, 1'b1, 1'b0, 1'b1, 5, "R6");
        send_byte(8'h00); slot(1'b0, 1'b1, 1'b0, 1'b0, 0, "R9");
        open_frame();
        send_byte(8'h6D); slot(1'b0, 1'b0, 1'b0, 1'b0, 0, "R6");
        busy = 1'b0;

        // R8: write stopped before data
        open_frame();
        send_byte(8'h6C); slot(1'b0, 1'b0, 1'b0, 1'b0, 0, "R8");

        // R10: no-data commands
        open_frame();
        send_byte(8'h6D); slot(1'b0, 1'b1, 1'b1, 1'b1, 7, "R10");
        open_frame();
        send_byte(8'h96); slot(1'b0, 1'b1, 1'b0, 1'b1, 3, "R10");
        open_frame();
        send_byte(8'h96); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R10");

        // R9: status write with data
        open_frame();
        send_byte(8'h6E); slot(1'b1, 1'b1, 1'b0, 1'b1, 6, "R9");
        send_byte(8'h0F); slot(1'b0, 1'b1, 1'b1, 1'b0, 0, "R9");

        // R11: sync loss between address and command
        open_frame();
        @(negedge clk); sync_err = 1'b1;
        @(negedge clk); sync_err = 1'b0;
        send_byte(8'h03); slot(1'b1, 1'b0, 1'b0, 1'b0, 0, "R11");

        // R12: standby mid-byte restarts header search
        sby();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        open_frame();
        send_byte(8'h03); slot(1'b1, 1'b1, 1'b0, 1'b1, 0, "R12");

        repeat (6) @(negedge clk);
        summary();
    end

endmodule